// File: doc/BRIEF.md
# Miss-Dependent Instruction Deferral Queue

This block sits beside a simple in-order pipeline and lets it keep working past a data-cache load miss. When a load misses while no speculation is running, the block pulses a checkpoint request and enters a speculative episode. From then on, each offered instruction is sorted. An instruction that reads only available registers goes ahead at once. A missing load, or an instruction that reads a register still waiting for a value, is parked in a 16-entry deferred queue. Its destination register is then marked as pending.

Each returning miss value clears the pending mark of its register and starts a drain pass. In a drain pass the behind context walks the entries that were queued when the pass began, one per cycle. An entry whose operands are now available is executed and frees its destination. An entry still blocked is written back at the tail with its age tag unchanged. When the queue empties, the block pulses commit and leaves speculation. A mis-speculation signal restores the checkpoint, flushes the queue and clears every pending mark in one cycle.

States: `ST_IDLE` (no speculation), `ST_SPEC` (ahead running, waiting for miss data), `ST_DRAIN` (drain pass in progress), `ST_COMMIT` (one-cycle release). Transitions: IDLE→SPEC on a triggering miss. SPEC→DRAIN on a fill. DRAIN→DRAIN after a pass if a fill arrived during it. DRAIN→SPEC after a pass that left entries and saw no fill. DRAIN→COMMIT after a pass that empties the queue. COMMIT→IDLE always. SPEC, DRAIN or COMMIT go to IDLE on mis-speculation.

Top module: `miss_defer_unit`

## Requirements
- R1: After reset `spec_active`, `beh_valid`, `redefer`, `commit`, `ckpt_save` and `restore` are all 0, and `iss_ready` is 1 for an offered instruction that does not miss.
- R2: Outside speculation, an accepted instruction with `iss_miss`=0 raises `ahead_go` without any checkpoint. An accepted instruction with `iss_miss`=1 raises `defer_go` and `ckpt_save` in the same cycle, becomes age tag 0, and `spec_active` is 1 from the next cycle.
- R3: During speculation, an accepted instruction is deferred (`defer_go`) if it is a missing load or if either source register is pending. Its destination becomes pending. Each new deferral takes the next age tag, counting up from the triggering miss.
- R4: An instruction that is not a missing load and whose sources are both not pending is accepted with `ahead_go` in the cycle it is offered, in every state except the commit cycle.
- R5: An instruction whose destination register is pending is held (`iss_ready`=0) until that register becomes available.
- R6: The queue holds 16 entries. When it is full, an instruction that needs deferral is held, while independent instructions still go ahead.
- R7: A fill (`fill_valid`, `fill_reg`) clears the pending mark of that register. A fill during speculation starts a drain pass in the next cycle, covering exactly the entries queued at that point.
- R8: A drain pass handles one head entry per cycle, in queue order. An entry is ready when neither source is pending and, for a missing load, its own destination is no longer pending. A ready entry shows `beh_valid` with its opcode, destination and tag, and its destination stops being pending. A blocked entry pulses `redefer` and returns to the tail with its tag unchanged.
- R9: While a drain pass runs, an instruction that needs deferral is held.
- R10: A pass that leaves the queue empty is followed by exactly one `commit` pulse, and then speculation ends. A pass that leaves entries waits for the next fill, or starts again at once if a fill arrived during the pass.
- R11: `mispec` during speculation pulses `restore` in the same cycle and holds `iss_ready` low. From the next cycle the queue is empty, no register is pending and `spec_active` is 0, so a former dependent goes ahead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Instruction offered by the pipeline |
| iss_op | input | 8 | Opcode of the offered instruction |
| iss_src_a | input | 5 | First source register index |
| iss_src_b | input | 5 | Second source register index |
| iss_dst | input | 5 | Destination register index |
| iss_miss | input | 1 | Offered instruction is a load that missed in L1 |
| iss_ready | output | 1 | Offered instruction can be accepted this cycle |
| ahead_go | output | 1 | Accepted instruction executes in the ahead context |
| defer_go | output | 1 | Accepted instruction is written to the deferred queue |
| fill_valid | input | 1 | Miss data returned |
| fill_reg | input | 5 | Destination register of the returned miss |
| mispec | input | 1 | Mis-speculation signalled |
| beh_valid | output | 1 | Behind context executes the head entry |
| beh_op | output | 8 | Opcode of the executed entry |
| beh_dst | output | 5 | Destination of the executed entry |
| beh_tag | output | 6 | Age tag of the executed entry |
| redefer | output | 1 | Head entry still blocked and written back |
| ckpt_save | output | 1 | Take the architectural checkpoint |
| commit | output | 1 | Release the checkpoint; episode finished |
| restore | output | 1 | Restore the checkpoint |
| spec_active | output | 1 | A speculative episode is in progress |

## Verification
A pending mark left set by mistake shows at the ports within one cycle, as a held `iss_ready` or a wrong `ahead_go`/`defer_go` split. After the next fill it appears as a `redefer` pulse where an execution was due, and the `commit` pulse never comes. A corrupted queue pointer or a lost tail write shows within one pass as a behind execution with the wrong opcode, destination or tag, or in the wrong order. The scoreboard therefore compares every `beh_valid` cycle against a predicted sequence. It also counts `redefer` and `commit` pulses per episode, and it checks the accept outputs in each offer cycle.

// File: rtl/mdq_pkg.sv
package mdq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SPEC   = 2'd1,
        ST_DRAIN  = 2'd2,
        ST_COMMIT = 2'd3
    } mdq_state_e;

endpackage

// File: rtl/mdq_fifo.sv
module mdq_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rptr, wptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rptr  <= '0;
            wptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= bump(wptr);
            if (pop)  rptr <= bump(rptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assign rdata = mem[rptr];
    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/mdq_pending.sv
module mdq_pending #(
    parameter int NREG = 32,
    localparam int REG_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_all,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_idx,
    input  logic             clr_a_en,
    input  logic [REG_W-1:0] clr_a_idx,
    input  logic             clr_b_en,
    input  logic [REG_W-1:0] clr_b_idx,
    output logic [NREG-1:0]  pend
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic bit_q;
        logic hit_set, hit_clr;

        assign hit_set = set_en && (set_idx == REG_W'(i));
        assign hit_clr = (clr_a_en && (clr_a_idx == REG_W'(i))) ||
                         (clr_b_en && (clr_b_idx == REG_W'(i)));

        always_ff @(posedge clk) begin
            if (!rst_n || clear_all) bit_q <= 1'b0;
            else if (hit_set)        bit_q <= 1'b1;
            else if (hit_clr)        bit_q <= 1'b0;
        end

        assign pend[i] = bit_q;
    end

endmodule

// File: rtl/miss_defer_unit.sv
module miss_defer_unit
    import mdq_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int OP_W  = 8,
    parameter int DEPTH = 16,
    parameter int TAG_W = 6,
    localparam int REG_W = $clog2(NREG),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic [OP_W-1:0]  iss_op,
    input  logic [REG_W-1:0] iss_src_a,
    input  logic [REG_W-1:0] iss_src_b,
    input  logic [REG_W-1:0] iss_dst,
    input  logic             iss_miss,
    output logic             iss_ready,
    output logic             ahead_go,
    output logic             defer_go,
    input  logic             fill_valid,
    input  logic [REG_W-1:0] fill_reg,
    input  logic             mispec,
    output logic             beh_valid,
    output logic [OP_W-1:0]  beh_op,
    output logic [REG_W-1:0] beh_dst,
    output logic [TAG_W-1:0] beh_tag,
    output logic             redefer,
    output logic             ckpt_save,
    output logic             commit,
    output logic             restore,
    output logic             spec_active
);

    localparam int ENT_W = 1 + TAG_W + OP_W + 3 * REG_W;

    mdq_state_e       state_q, state_n;
    logic [CNT_W-1:0] pass_q, pass_n;
    logic             fill_seen_q, fill_seen_n;
    logic [TAG_W-1:0] tag_q, new_tag;

    logic [NREG-1:0]  pend;
    logic [ENT_W-1:0] head, new_ent, wr_ent;
    logic [CNT_W-1:0] q_count, cnt_after;
    logic             q_full, q_empty, q_push, q_pop;

    logic             h_miss;
    logic [TAG_W-1:0] h_tag;
    logic [OP_W-1:0]  h_op;
    logic [REG_W-1:0] h_a, h_b, h_dst;
    logic             head_ready, in_drain;
    logic             src_busy, dst_busy, need_defer, accept;

    // ---------------- sorting of offered instructions ----------------
    assign src_busy   = pend[iss_src_a] || pend[iss_src_b];
    assign dst_busy   = pend[iss_dst];
    assign need_defer = iss_miss || src_busy;
    assign in_drain   = (state_q == ST_DRAIN);

    assign new_tag = (state_q == ST_IDLE) ? '0 : tag_q;
    assign new_ent = {iss_miss, new_tag, iss_op, iss_src_a, iss_src_b, iss_dst};
    assign {h_miss, h_tag, h_op, h_a, h_b, h_dst} = head;

    assign head_ready = !pend[h_a] && !pend[h_b] && (!h_miss || !pend[h_dst]);

    // ---------------- output process ----------------
    always_comb begin
        iss_ready = 1'b1;
        if (mispec || state_q == ST_COMMIT || dst_busy) iss_ready = 1'b0;
        if (need_defer && (q_full || in_drain))         iss_ready = 1'b0;
        accept      = iss_valid && iss_ready;
        ahead_go    = accept && !need_defer;
        defer_go    = accept && need_defer;
        ckpt_save   = defer_go && (state_q == ST_IDLE);
        restore     = mispec && (state_q != ST_IDLE);
        commit      = (state_q == ST_COMMIT) && !mispec;
        spec_active = (state_q != ST_IDLE);
        beh_valid   = in_drain && !mispec && head_ready;
        redefer     = in_drain && !mispec && !head_ready;
        beh_op      = h_op;
        beh_dst     = h_dst;
        beh_tag     = h_tag;
    end

    assign q_pop     = beh_valid || redefer;
    assign q_push    = defer_go || redefer;
    assign wr_ent    = redefer ? head : new_ent;
    assign cnt_after = q_count - {{(CNT_W-1){1'b0}}, beh_valid};

    // ---------------- next-state logic ----------------
    always_comb begin
        state_n     = state_q;
        pass_n      = pass_q;
        fill_seen_n = fill_seen_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ckpt_save) state_n = ST_SPEC;
            end
            ST_SPEC: begin
                if (restore) begin
                    state_n = ST_IDLE;
                end else if (fill_valid) begin
                    state_n     = ST_DRAIN;
                    pass_n      = q_count + {{(CNT_W-1){1'b0}}, defer_go};
                    fill_seen_n = 1'b0;
                end
            end
            ST_DRAIN: begin
                if (restore) begin
                    state_n = ST_IDLE;
                end else if (pass_q == CNT_W'(1)) begin
                    fill_seen_n = 1'b0;
                    if (cnt_after == '0) begin
                        state_n = ST_COMMIT;
                    end else if (fill_seen_q || fill_valid) begin
                        pass_n = cnt_after;
                    end else begin
                        state_n = ST_SPEC;
                    end
                end else begin
                    pass_n      = pass_q - 1'b1;
                    fill_seen_n = fill_seen_q || fill_valid;
                end
            end
            ST_COMMIT: begin
                state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            pass_q      <= '0;
            fill_seen_q <= 1'b0;
            tag_q       <= '0;
        end else begin
            state_q     <= state_n;
            pass_q      <= pass_n;
            fill_seen_q <= fill_seen_n;
            if (defer_go) tag_q <= new_tag + 1'b1;
        end
    end

    mdq_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (restore),
        .push  (q_push),
        .wdata (wr_ent),
        .pop   (q_pop),
        .rdata (head),
        .count (q_count),
        .full  (q_full),
        .empty (q_empty)
    );

    mdq_pending #(.NREG(NREG)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_all (restore),
        .set_en    (defer_go),
        .set_idx   (iss_dst),
        .clr_a_en  (fill_valid),
        .clr_a_idx (fill_reg),
        .clr_b_en  (beh_valid),
        .clr_b_idx (h_dst),
        .pend      (pend)
    );

    // ---------------- assertions ----------------
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q_push && q_full) |-> q_pop);

    p_ckpt_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ckpt_save && !mispec) |=> spec_active);

    p_defer_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        defer_go |=> pend[$past(iss_dst)]);

    p_hold_dst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && pend[iss_dst]) |-> !iss_ready);

    p_beh_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({beh_valid, redefer}));

    p_drain_no_defer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_drain |-> !defer_go);

    p_commit_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (q_empty && pend == '0));

    p_restore_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (q_empty && pend == '0 && !spec_active));

endmodule

// File: tb/tb_miss_defer_unit.sv
module tb_miss_defer_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iss_valid = 1'b0;
    logic [7:0] iss_op = '0;
    logic [4:0] iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
    logic       iss_miss = 1'b0;
    logic       fill_valid = 1'b0;
    logic [4:0] fill_reg = '0;
    logic       mispec = 1'b0;
    logic       iss_ready, ahead_go, defer_go, beh_valid, redefer;
    logic [7:0] beh_op;
    logic [4:0] beh_dst;
    logic [5:0] beh_tag;
    logic       ckpt_save, commit, restore, spec_active;

    int tests = 0, fails = 0;
    int n_redefer = 0, n_commit = 0, n_beh = 0;
    logic [18:0] exp_q [$];
    bit done = 0;

    always #4 clk = ~clk;

    miss_defer_unit dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: offer one instruction and check the accept outputs
    task automatic issue(input logic [7:0] op, input logic [4:0] a, input logic [4:0] b,
                         input logic [4:0] d, input bit miss,
                         input bit e_ready, input bit e_ahead, input bit e_ckpt,
                         input string req);
        @(negedge clk);
        iss_valid = 1'b1; iss_op = op; iss_src_a = a; iss_src_b = b;
        iss_dst = d; iss_miss = miss;
        #1;
        chk(iss_ready == e_ready, {req, " iss_ready"}, iss_ready, e_ready);
        chk(ahead_go == (e_ready && e_ahead), {req, " ahead_go"}, ahead_go, e_ready && e_ahead);
        chk(defer_go == (e_ready && !e_ahead), {req, " defer_go"}, defer_go, e_ready && !e_ahead);
        chk(ckpt_save == e_ckpt, {req, " ckpt_save"}, ckpt_save, e_ckpt);
        @(posedge clk); #1;
        iss_valid = 1'b0; iss_miss = 1'b0;
    endtask

    task automatic fill(input logic [4:0] r);
        @(negedge clk);
        fill_valid = 1'b1; fill_reg = r;
        @(posedge clk); #1;
        fill_valid = 1'b0;
    endtask

    task automatic expect_beh(input logic [7:0] op, input logic [4:0] d, input logic [5:0] t);
        exp_q.push_back({op, d, t});
    endtask

    // monitor: compare behind executions with the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (redefer) n_redefer++;
            if (commit)  n_commit++;
            if (beh_valid) begin
                n_beh++;
                if (exp_q.size() == 0) begin
                    chk(0, "R8 unexpected behind execution", {beh_op, beh_dst, beh_tag}, 0);
                end else begin
                    logic [18:0] e;
                    e = exp_q.pop_front();
                    chk({beh_op, beh_dst, beh_tag} == e, "R8 behind op/dst/tag",
                        {beh_op, beh_dst, beh_tag}, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            chk(0, "watchdog", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        iss_valid = 1'b1; iss_dst = 5'd3; #1;
        chk(spec_active == 0, "R1 spec_active", spec_active, 0);
        chk(iss_ready == 1, "R1 iss_ready", iss_ready, 1);
        chk(!beh_valid && !redefer && !commit && !ckpt_save && !restore, "R1 quiet outputs",
            {beh_valid, redefer, commit, ckpt_save, restore}, 0);
        iss_valid = 1'b0;

        // R2: independent outside speculation, then triggering miss
        issue(8'h11, 5'd4, 5'd5, 5'd6, 0, 1, 1, 0, "R2 idle ahead");
        issue(8'h20, 5'd0, 5'd0, 5'd1, 1, 1, 0, 1, "R2 trigger miss");
        chk(spec_active == 1, "R2 spec_active", spec_active, 1);
        issue(8'h21, 5'd1, 5'd0, 5'd2, 0, 1, 0, 0, "R3 dependent deferred");
        issue(8'h22, 5'd4, 5'd5, 5'd3, 0, 1, 1, 0, "R4 independent ahead");
        issue(8'h23, 5'd2, 5'd6, 5'd4, 0, 1, 0, 0, "R3 chained dependent");
        issue(8'h24, 5'd7, 5'd7, 5'd1, 0, 0, 1, 0, "R5 pending dst held");
        expect_beh(8'h20, 5'd1, 6'd0);
        expect_beh(8'h21, 5'd2, 6'd1);
        expect_beh(8'h23, 5'd4, 6'd2);
        fill(5'd1);
        repeat (6) @(posedge clk);
        chk(n_beh == 3, "R7 pass executed all", n_beh, 3);
        chk(n_commit == 1, "R10 one commit", n_commit, 1);
        chk(spec_active == 0, "R10 spec ends", spec_active, 0);

        // overlapping misses with re-deferral
        issue(8'h30, 5'd0, 5'd0, 5'd1, 1, 1, 0, 1, "R2 second episode");
        issue(8'h31, 5'd0, 5'd0, 5'd2, 1, 1, 0, 0, "R3 overlapping miss");
        issue(8'h32, 5'd2, 5'd0, 5'd3, 0, 1, 0, 0, "R3 dep on second miss");
        expect_beh(8'h30, 5'd1, 6'd0);
        fill(5'd1);
        issue(8'h33, 5'd2, 5'd0, 5'd7, 0, 0, 0, 0, "R9 deferral held in drain");
        issue(8'h34, 5'd9, 5'd10, 5'd8, 0, 1, 1, 0, "R4 independent during drain");
        repeat (4) @(posedge clk);
        chk(n_redefer == 2, "R8 redefer count", n_redefer, 2);
        chk(spec_active == 1, "R10 waits for fill", spec_active, 1);
        chk(n_commit == 1, "R10 no early commit", n_commit, 1);
        expect_beh(8'h31, 5'd2, 6'd1);
        expect_beh(8'h32, 5'd3, 6'd2);
        fill(5'd2);
        repeat (6) @(posedge clk);
        chk(n_commit == 2, "R10 commit after second fill", n_commit, 2);
        chk(n_beh == 6, "R8 all behind executions", n_beh, 6);

        // fill the queue, then mis-speculate
        issue(8'h40, 5'd0, 5'd0, 5'd1, 1, 1, 0, 1, "R2 third episode");
        for (int i = 2; i <= 16; i++)
            issue(8'h41, 5'd1, 5'd0, 5'(i), 0, 1, 0, 0, "R6 filling queue");
        issue(8'h42, 5'd1, 5'd0, 5'd20, 0, 0, 0, 0, "R6 full holds deferral");
        issue(8'h43, 5'd22, 5'd23, 5'd21, 0, 1, 1, 0, "R6 full passes independent");
        @(negedge clk);
        mispec = 1'b1; iss_valid = 1'b1; iss_op = 8'h44; iss_src_a = 5'd1; iss_dst = 5'd20; #1;
        chk(restore == 1, "R11 restore pulse", restore, 1);
        chk(iss_ready == 0, "R11 no accept", iss_ready, 0);
        @(posedge clk); #1;
        mispec = 1'b0; iss_valid = 1'b0;
        chk(spec_active == 0, "R11 spec cleared", spec_active, 0);
        issue(8'h45, 5'd1, 5'd2, 5'd20, 0, 1, 1, 0, "R11 former dependent ahead");
        repeat (4) @(posedge clk);
        chk(n_beh == 6 && n_commit == 2, "R11 no behind after flush", n_beh, 6);
        chk(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);

        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule